// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine with Resumable Addressing

This block moves a programmed number of bytes between two ports, called A and B. Each port has a start address, an address-step mode (step up, step down or hold) and a space tag that marks it as memory or I/O. A direction bit chooses which port is the source. Every byte takes one read on the bus, then one write of the byte that was read. A small register file holds the settings, and a command input acts on them.

The LOAD command copies the start addresses into the live address counters and clears the byte counter. The CONTINUE command clears only the byte counter, so the next block carries on from the live addresses. Start addresses written since the last block have no effect on a CONTINUE. ENABLE starts the transfer and DISABLE stops it at the next byte boundary. Settings stay in place between blocks, so software rewrites only what changes. An 8-bit pacing value adds idle cycles between bytes. An auto-repeat flag reloads the addresses and starts the block again each time it ends.

Both bus phases use valid/ready. The engine raises `rd_req` or `wr_req` with a stable address and holds it until the matching ready is high on a clock edge. A low ready stalls the engine for as long as it stays low, and nothing is dropped. Only one of the two requests is high at any time.

Top module: `bytemover_dma`

## Requirements
- R1: After reset `rd_req`, `wr_req`, `busy` and `done` are all 0.
- R2: A LOAD command copies the start addresses of both ports into the live address counters and clears the byte counter. The command code for LOAD is 0.
- R3: After ENABLE (code 2), the engine performs exactly `len` read/write byte pairs and then sets `done` and drops `busy`. A length of 0 sets `done` and performs no bus access.
- R4: Each port steps by its own mode after every written byte. Mode 0 adds one, mode 1 subtracts one, and modes 2 and 3 hold the address. Port A's mode sits in control bits [1:0] and port B's mode in control bits [4:3].
- R5: Control bit 6 selects the direction: 0 moves A to B and 1 moves B to A. Control bits 2 and 5 tag port A and port B as I/O. `rd_io` and `wr_io` carry the tag of the source and the destination.
- R6: A CONTINUE command (code 1) clears only the byte counter. The next block resumes at the live addresses, and start addresses written since the last block have no effect.
- R7: Register contents persist across blocks. A new block that reuses the earlier length, modes and direction needs only a command.
- R8: With a pacing value P (register select 4, bits [7:0]) and both readies held high, consecutive write handshakes are exactly P+2 cycles apart.
- R9: With control bit 7 set, the last byte of a block reloads both live addresses from their start registers and clears the counter. The transfer goes on without stopping and never sets `done`.
- R10: A request stays high with a stable address and space tag until its ready is seen. `rd_req` and `wr_req` are never high together. The written byte equals the byte read for that pair.
- R11: ENABLE clears `done`. DISABLE (code 3) lets the byte in flight finish, and after that no further requests are made.

Register selects: 0 is the port A start address, 1 is the port B start address, 2 is the length, 3 is the control byte and 4 is the pacing value. LOAD and CONTINUE are taken only while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command code: 0 LOAD, 1 CONTINUE, 2 ENABLE, 3 DISABLE |
| rd_req | output | 1 | Read request (valid) |
| rd_addr | output | AW | Read address |
| rd_io | output | 1 | Read targets I/O space |
| rd_ready | input | 1 | Read accepted; `rd_data` valid |
| rd_data | input | 8 | Read data |
| wr_req | output | 1 | Write request (valid) |
| wr_addr | output | AW | Write address |
| wr_io | output | 1 | Write targets I/O space |
| wr_data | output | 8 | Write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Transfer enabled or a byte in flight |
| done | output | 1 | Block finished without auto-repeat |

## Verification
A wrong byte counter shows up at the ports as one write too many or one too few before `done` rises, and it shows within one block. A live address that drifts or is reloaded at the wrong time puts the very next write at the wrong address. The resume test catches an address counter that reloads wrongly on CONTINUE at the first byte after it. A pacing counter that is off by one changes the gap between write handshakes at the second byte, and an auto-repeat fault puts the wrong address on the first write after the block boundary.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic [1:0] {
    AM_INC  = 2'd0,
    AM_DEC  = 2'd1,
    AM_HOLD = 2'd2,
    AM_HLD2 = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    CMD_LOAD    = 2'd0,
    CMD_CONT    = 2'd1,
    CMD_ENABLE  = 2'd2,
    CMD_DISABLE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WAIT  = 2'd3
  } state_e;

  // control byte: [7] repeat, [6] B->A, [5] B io, [4:3] B mode, [2] A io, [1:0] A mode
  typedef struct packed {
    logic   repeat_en;
    logic   b_to_a;
    logic   b_io;
    amode_e b_mode;
    logic   a_io;
    amode_e a_mode;
  } ctrl_t;

  localparam logic [2:0] SEL_A_START = 3'd0;
  localparam logic [2:0] SEL_B_START = 3'd1;
  localparam logic [2:0] SEL_LEN     = 3'd2;
  localparam logic [2:0] SEL_CTRL    = 3'd3;
  localparam logic [2:0] SEL_PACE    = 3'd4;

endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
  import bmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] a_start,
  output logic [AW-1:0] b_start,
  output logic [AW-1:0] len,
  output ctrl_t         ctrl,
  output logic [PW-1:0] pace
);

  localparam int CW = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_start <= '0;
      b_start <= '0;
      len     <= '0;
      ctrl    <= '0;
      pace    <= '0;
    end else if (we) begin
      unique case (sel)
        SEL_A_START: a_start <= wdata;
        SEL_B_START: b_start <= wdata;
        SEL_LEN:     len     <= wdata;
        SEL_CTRL:    ctrl    <= ctrl_t'(wdata[CW-1:0]);
        SEL_PACE:    pace    <= wdata[PW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bmd_addr_gen.sv
module bmd_addr_gen
  import bmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  amode_e        mode,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= start;
    end else if (step) begin
      unique case (mode)
        AM_INC:  addr <= addr + AW'(1);
        AM_DEC:  addr <= addr - AW'(1);
        default: addr <= addr;
      endcase
    end
  end

  // R4: a holding port never moves on a step
  a_r4_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (mode == AM_HOLD || mode == AM_HLD2)) |=> $stable(addr));

  // R2: a load lands the start address
  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (load && $stable(start)) |=> (addr == $past(start)));

endmodule

// File: rtl/bmd_pacer.sv
module bmd_pacer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] pace,
  output logic          expired
);

  logic [PW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= pace;
    end else if (remain != '0) begin
      remain <= remain - PW'(1);
    end
  end

  assign expired = (remain <= PW'(1));

  // R8: a loaded nonzero delay is not expired on the next cycle unless it was 1
  a_r8_pace_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pace > PW'(1)) |=> !expired);

endmodule

// File: rtl/bytemover_dma.sv
module bytemover_dma
  import bmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_io,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic          wr_io,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done
);

  localparam int NPORT = 2;

  logic [AW-1:0] a_start, b_start, len;
  ctrl_t         ctrl;
  logic [PW-1:0] pace;

  bmd_regs #(.AW(AW), .PW(PW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .a_start(a_start), .b_start(b_start), .len(len), .ctrl(ctrl), .pace(pace)
  );

  state_e        state;
  logic          run;
  logic [AW-1:0] cnt;
  logic [DW-1:0] data_q;

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_code);

  logic idle_now, load_cmd, cont_cmd, stop_req, enable_cmd;
  assign idle_now   = (state == ST_IDLE) && !run;
  assign load_cmd   = cmd_valid && (cmd == CMD_LOAD) && idle_now;
  assign cont_cmd   = cmd_valid && (cmd == CMD_CONT) && idle_now;
  assign enable_cmd = cmd_valid && (cmd == CMD_ENABLE);
  assign stop_req   = cmd_valid && (cmd == CMD_DISABLE);

  logic rd_hs, wr_hs, last, restart;
  assign rd_hs   = (state == ST_READ) && rd_ready;
  assign wr_hs   = (state == ST_WRITE) && wr_ready;
  assign last    = ((cnt + AW'(1)) == len);
  assign restart = wr_hs && last && ctrl.repeat_en;

  // live address counters, one per port
  logic [NPORT-1:0][AW-1:0] port_start, port_addr;
  amode_e                   port_mode [NPORT];
  assign port_start[0] = a_start;
  assign port_start[1] = b_start;
  assign port_mode[0]  = ctrl.a_mode;
  assign port_mode[1]  = ctrl.b_mode;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bmd_addr_gen #(.AW(AW)) addr_i (
      .clk(clk), .rst_n(rst_n),
      .load(load_cmd || restart),
      .step(wr_hs && !restart),
      .mode(port_mode[p]),
      .start(port_start[p]),
      .addr(port_addr[p])
    );
  end

  logic pace_expired;
  bmd_pacer #(.PW(PW)) pacer_i (
    .clk(clk), .rst_n(rst_n), .start(wr_hs), .pace(pace), .expired(pace_expired)
  );

  // byte counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_cmd || cont_cmd) begin
      cnt <= '0;
    end else if (wr_hs) begin
      cnt <= restart ? '0 : cnt + AW'(1);
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      run    <= 1'b0;
      done   <= 1'b0;
      data_q <= '0;
    end else begin
      if (enable_cmd) begin
        run  <= 1'b1;
        done <= 1'b0;
      end else if (stop_req) begin
        run <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (run && !stop_req) begin
            if (cnt < len) begin
              state <= ST_READ;
            end else begin
              run  <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rd_ready) begin
            data_q <= rd_data;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (last && !ctrl.repeat_en) begin
              state <= ST_IDLE;
              run   <= 1'b0;
              done  <= 1'b1;
            end else if (!run || stop_req) begin
              state <= ST_IDLE;
            end else if (pace != '0) begin
              state <= ST_WAIT;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_WAIT: begin
          if (!run || stop_req) begin
            state <= ST_IDLE;
          end else if (pace_expired) begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // bus side
  logic [AW-1:0] src_addr, dst_addr;
  logic          src_io, dst_io;
  assign src_addr = ctrl.b_to_a ? port_addr[1] : port_addr[0];
  assign dst_addr = ctrl.b_to_a ? port_addr[0] : port_addr[1];
  assign src_io   = ctrl.b_to_a ? ctrl.b_io : ctrl.a_io;
  assign dst_io   = ctrl.b_to_a ? ctrl.a_io : ctrl.b_io;

  assign rd_req  = (state == ST_READ);
  assign rd_addr = src_addr;
  assign rd_io   = src_io;
  assign wr_req  = (state == ST_WRITE);
  assign wr_addr = dst_addr;
  assign wr_io   = dst_io;
  assign wr_data = data_q;
  assign busy    = run || (state != ST_IDLE);

  // R10: read request held with stable address until accepted
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr) && $stable(rd_io)));

  // R10: write request held with stable address and data until accepted
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R10: never both phases at once
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R10: the written byte is the byte just read
  a_r10_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |=> (wr_req && wr_data == $past(rd_data)));

  // R3: done never coexists with a bus request
  a_r3_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !wr_req));

  // R3: counter stays inside the block while bytes move
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (cnt < len));

  // R9: a repeating block boundary keeps the engine going
  a_r9_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && run && !stop_req) |=> (busy && !done));

  // R8: a nonzero pacing value keeps the next read off the bus
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && pace != '0) |=> !rd_req);

endmodule

// File: tb/bytemover_dma_tb_top.sv
module bytemover_dma_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_code = '0;
  logic          rd_req, rd_io, wr_req, wr_io, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          rd_ready, wr_ready;

  always #2.5 clk = ~clk;

  bytemover_dma #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_io(rd_io), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_io(wr_io), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ a[15:8];
  endfunction

  function automatic logic [7:0] io_b(input logic [AW-1:0] a);
    return 8'hC3 ^ {a[3:0], a[7:4]};
  endfunction

  // bus model
  logic       stall = 1'b0;
  logic [7:0] lfsr = 8'h1D;
  int         cyc = 0;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign rd_ready = !stall || lfsr[0];
  assign wr_ready = !stall || lfsr[3];
  assign rd_data  = rd_io ? io_b(rd_addr) : mem_b(rd_addr);

  // write log
  logic          log_clr = 1'b0;
  int            nlog = 0;
  logic [AW-1:0] la [64];
  logic [7:0]    ld [64];
  int            lt [64];
  logic          last_rd_io = 1'b0, last_wr_io = 1'b0;
  always @(posedge clk) begin
    if (log_clr) begin
      nlog <= 0;
    end else if (wr_req && wr_ready && nlog < 64) begin
      la[nlog] <= wr_addr;
      ld[nlog] <= wr_data;
      lt[nlog] <= cyc;
      last_wr_io <= wr_io;
      nlog <= nlog + 1;
    end
    if (rd_req && rd_ready) last_rd_io <= rd_io;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic command(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic setup(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic [AW-1:0] n, input logic [7:0] c, input logic [7:0] p);
    wr_reg(3'd0, a); wr_reg(3'd1, b); wr_reg(3'd2, n);
    wr_reg(3'd3, {8'h00, c}); wr_reg(3'd4, {8'h00, p});
  endtask

  task automatic t_reset();
    check(!rd_req && !wr_req, "R1 bus idle", {rd_req, wr_req}, 0);
    check(!busy && !done, "R1 status", {busy, done}, 0);
  endtask

  task automatic t_basic();
    setup(16'h0100, 16'h0200, 16'd4, 8'h00, 8'h00);
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(nlog == 4, "R3 byte count", nlog, 4);
    check(done && !busy, "R3 done/busy", {done, busy}, 2);
    for (int i = 0; i < 4; i++) begin
      check(la[i] == 16'h0200 + AW'(i), "R2/R4 inc dest addr", la[i], 16'h0200 + i);
      check(ld[i] == mem_b(16'h0100 + AW'(i)), "R10 data", ld[i], mem_b(16'h0100 + AW'(i)));
    end
    check(last_rd_io == 0 && last_wr_io == 0, "R5 memory tags", {last_rd_io, last_wr_io}, 0);
  endtask

  task automatic t_enable_clears();
    command(2'd2);
    check(!done && busy, "R11 enable clears done", {done, busy}, 1);
    wait_done();
  endtask

  task automatic t_modes();
    setup(16'h0130, 16'h0240, 16'd4, 8'h11, 8'h00);
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(nlog == 4, "R3 count dec/hold", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      check(la[i] == 16'h0240, "R4 hold dest", la[i], 16'h0240);
      check(ld[i] == mem_b(16'h0130 - AW'(i)), "R4 dec source", ld[i], mem_b(16'h0130 - AW'(i)));
    end
  endtask

  task automatic t_dir_io();
    setup(16'h0300, 16'h00FE, 16'd4, 8'h70, 8'h00);
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(nlog == 4, "R5 count B->A", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      check(la[i] == 16'h0300 + AW'(i), "R5 dest is A", la[i], 16'h0300 + i);
      check(ld[i] == io_b(16'h00FE), "R5 io data", ld[i], io_b(16'h00FE));
    end
    check(last_rd_io == 1 && last_wr_io == 0, "R5 io tags", {last_rd_io, last_wr_io}, 2);
  endtask

  task automatic t_continue();
    setup(16'h0400, 16'h0500, 16'd4, 8'h00, 8'h00);
    command(2'd0); command(2'd2); wait_done();
    wr_reg(3'd0, 16'h0700); wr_reg(3'd1, 16'h0800);
    clear_log();
    command(2'd1); command(2'd2); wait_done();
    check(nlog == 4, "R7 retained length", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      check(la[i] == 16'h0504 + AW'(i), "R6 resume dest", la[i], 16'h0504 + i);
      check(ld[i] == mem_b(16'h0404 + AW'(i)), "R6 resume src", ld[i], mem_b(16'h0404 + AW'(i)));
    end
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(la[0] == 16'h0800, "R2 load new dest", la[0], 16'h0800);
    check(ld[0] == mem_b(16'h0700), "R2 load new src", ld[0], mem_b(16'h0700));
  endtask

  task automatic t_pace();
    setup(16'h0100, 16'h0200, 16'd3, 8'h00, 8'h03);
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(lt[1] - lt[0] == 5, "R8 gap P=3 first", lt[1] - lt[0], 5);
    check(lt[2] - lt[1] == 5, "R8 gap P=3 second", lt[2] - lt[1], 5);
    wr_reg(3'd4, 16'h0000);
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    check(lt[1] - lt[0] == 2, "R8 gap P=0", lt[1] - lt[0], 2);
  endtask

  task automatic t_repeat();
    int n_before;
    setup(16'h0600, 16'h0900, 16'd3, 8'h80, 8'h00);
    clear_log();
    command(2'd0); command(2'd2);
    repeat (20) @(negedge clk);
    command(2'd3);
    repeat (6) @(negedge clk);
    n_before = nlog;
    check(nlog >= 7, "R9 keeps running", nlog, 7);
    check(!done, "R9 no done", done, 0);
    for (int i = 0; i < nlog; i++) begin
      check(la[i] == 16'h0900 + AW'(i % 3), "R9 restart addr", la[i], 16'h0900 + i % 3);
      check(ld[i] == mem_b(16'h0600 + AW'(i % 3)), "R9 restart data", ld[i], mem_b(16'h0600 + AW'(i % 3)));
    end
    repeat (6) @(negedge clk);
    check(nlog == n_before && !rd_req && !wr_req && !busy, "R11 disable quiet", nlog, n_before);
  endtask

  task automatic t_stall();
    setup(16'h0A00, 16'h0B00, 16'd5, 8'h00, 8'h00);
    stall = 1'b1;
    clear_log();
    command(2'd0); command(2'd2); wait_done();
    stall = 1'b0;
    check(nlog == 5, "R10 count under stall", nlog, 5);
    for (int i = 0; i < 5; i++) begin
      check(la[i] == 16'h0B00 + AW'(i), "R10 stall addr", la[i], 16'h0B00 + i);
      check(ld[i] == mem_b(16'h0A00 + AW'(i)), "R10 stall data", ld[i], mem_b(16'h0A00 + AW'(i)));
    end
  endtask

  task automatic t_zero();
    wr_reg(3'd2, 16'd0);
    clear_log();
    command(2'd0); command(2'd2);
    repeat (5) @(negedge clk);
    check(done && !busy, "R3 zero length done", {done, busy}, 2);
    check(nlog == 0, "R3 zero length no access", nlog, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_enable_clears();
    t_modes();
    t_dir_io();
    t_continue();
    t_pace();
    t_repeat();
    t_stall();
    t_zero();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule